// File: doc/BRIEF.md
# Guest/Nested Permission Combiner

This block takes the attribute bits of two page-table leaf entries for a single memory access and produces the effective permissions. One entry comes from the guest's own tables. The other comes from the nested tables that map guest-physical to system-physical memory. The block sits beside a two-level table walker. When the walker has both leaves in hand, it strobes the block, and one clock later it receives three things:

- whether the access breaks a guest-level rule, which is delivered to the guest as a page fault;
- whether it breaks a nested-level rule, which is an exit to the hypervisor;
- the merged writable, executable, user and global attributes to place in the TLB.

Each attribute follows its own rule:

- Writable and executable must be allowed at both levels.
- User and global are taken from the guest entry alone.
- The nested entry must be marked user, or every access fails at the nested level.

There are no inputs for the host's write-protect bit, the host's global-page enable or the nested entry's global bit. Under nested translation none of them can change any output.

Top module: `perm_combiner`

## Requirements
- R1: While `rst` is high at a clock edge, every output register is cleared to 0 at that edge.
- R2: On a clock edge where `req_valid` is high, all results are computed from the inputs sampled at that edge and appear on the outputs after it, and `out_valid` is 1. On an edge with `req_valid` low, `out_valid` becomes 0 and all other outputs keep their values.
- R3: `eff_wr` is 1 only when both `g_wr` and `n_wr` are 1. The guest write-protect bit `g_wp` never changes `eff_wr`.
- R4: The access code `acc` is 00 read, 01 write, 10 instruction fetch, and 11 is treated as read. A write with `g_wr`=0 raises `g_fault` in two cases: when `cpl` is 3, whatever the value of `g_wp`, or when `cpl` is 0 to 2 and `g_wp` is 1.
- R5: `eff_x` is 1 only when both levels allow execution. The guest level allows it when `g_nxe`=0 or `g_nx`=0. The nested level allows it when `h_nxe`=0 or `n_nx`=0.
- R6: A fetch raises `g_fault` when `g_nxe`=1 and `g_nx`=1. A fetch raises `n_fault` when `h_nxe`=1 and `n_nx`=1.
- R7: `eff_glb` equals `g_glb`, and `eff_usr` equals `g_usr`.
- R8: An access at `cpl`=3 with `g_usr`=0 raises `g_fault`. Any access with `n_usr`=0 raises `n_fault`. A write with `n_wr`=0 raises `n_fault` whatever `g_wp` and `cpl` are.
- R9: When both guest-level and nested-level rules are violated, only `g_fault` is set and `n_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Strobe: sample the inputs and register the results |
| g_wr | input | 1 | Guest leaf writable bit |
| g_usr | input | 1 | Guest leaf user bit |
| g_nx | input | 1 | Guest leaf no-execute bit |
| g_glb | input | 1 | Guest leaf global bit |
| n_wr | input | 1 | Nested leaf writable bit |
| n_usr | input | 1 | Nested leaf user bit |
| n_nx | input | 1 | Nested leaf no-execute bit |
| g_nxe | input | 1 | Guest no-execute enable |
| h_nxe | input | 1 | Host no-execute enable |
| g_wp | input | 1 | Guest write-protect control |
| cpl | input | 2 | Guest privilege level, 3 is user |
| acc | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 read |
| out_valid | output | 1 | Results registered on the previous edge |
| g_fault | output | 1 | Guest-level fault |
| n_fault | output | 1 | Nested-level fault |
| eff_wr | output | 1 | Effective writable attribute |
| eff_x | output | 1 | Effective executable attribute |
| eff_usr | output | 1 | Effective user attribute |
| eff_glb | output | 1 | Effective global attribute |

## Verification
On every cycle, the assertions check four things:

- the two fault flags are never set together;
- a writable result always had both writable bits set in the strobed inputs;
- the global and user results follow the guest bits;
- a nested entry without the user bit faults unless a guest fault takes priority.

They also check that outputs hold still between strobes. The write-protect and privilege interplay, the effect of the no-execute enables on fetches, and the exact fault selection for each access type can only be shown by the bench. It drives a sweep of every combination of leaf bits, controls, privilege and access type and compares each result with its reference model.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic wr;
    logic usr;
    logic nx;
  } leaf_t;

  typedef struct packed {
    logic g_fault;
    logic n_fault;
    logic wr;
    logic x;
    logic usr;
    logic glb;
  } result_t;
endpackage

// File: rtl/guest_check.sv
module guest_check #(
  parameter int CPL_W    = 2,
  parameter int USER_CPL = 3
) (
  input  perm_pkg::leaf_t  leaf,
  input  logic             nxe,
  input  logic             wp,
  input  logic [CPL_W-1:0] cpl,
  input  perm_pkg::acc_e   acc,
  output logic             fault,
  output logic             exec_ok
);
  import perm_pkg::*;
  localparam logic [CPL_W-1:0] UCPL = CPL_W'(USER_CPL);

  logic is_user, wr_bad, usr_bad, fx_bad;

  always_comb begin
    is_user = (cpl == UCPL);
    exec_ok = !(nxe && leaf.nx);
    // read-only guest page: user level always faults, supervisor only with wp
    wr_bad  = (acc == ACC_WRITE) && !leaf.wr && (is_user || wp);
    usr_bad = is_user && !leaf.usr;
    fx_bad  = (acc == ACC_FETCH) && !exec_ok;
    fault   = wr_bad || usr_bad || fx_bad;
  end
endmodule

// File: rtl/nested_check.sv
module nested_check (
  input  perm_pkg::leaf_t leaf,
  input  logic            nxe,
  input  perm_pkg::acc_e  acc,
  output logic            fault,
  output logic            exec_ok
);
  import perm_pkg::*;
  logic wr_bad, fx_bad;

  always_comb begin
    exec_ok = !(nxe && leaf.nx);
    // every guest access is a user access at this level
    wr_bad  = (acc == ACC_WRITE) && !leaf.wr;
    fx_bad  = (acc == ACC_FETCH) && !exec_ok;
    fault   = !leaf.usr || wr_bad || fx_bad;
  end
endmodule

// File: rtl/attr_merge.sv
module attr_merge (
  input  perm_pkg::leaf_t   g_leaf,
  input  perm_pkg::leaf_t   n_leaf,
  input  logic              g_glb,
  input  logic              g_fault_in,
  input  logic              n_fault_in,
  input  logic              g_exec_ok,
  input  logic              n_exec_ok,
  output perm_pkg::result_t res
);
  always_comb begin
    res.g_fault = g_fault_in;
    res.n_fault = n_fault_in && !g_fault_in;
    res.wr      = g_leaf.wr && n_leaf.wr;
    res.x       = g_exec_ok && n_exec_ok;
    res.usr     = g_leaf.usr;
    res.glb     = g_glb;
  end
endmodule

// File: rtl/perm_combiner.sv
module perm_combiner #(
  parameter int CPL_W    = 2,
  parameter int USER_CPL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             g_wr,
  input  logic             g_usr,
  input  logic             g_nx,
  input  logic             g_glb,
  input  logic             n_wr,
  input  logic             n_usr,
  input  logic             n_nx,
  input  logic             g_nxe,
  input  logic             h_nxe,
  input  logic             g_wp,
  input  logic [CPL_W-1:0] cpl,
  input  logic [1:0]       acc,
  output logic             out_valid,
  output logic             g_fault,
  output logic             n_fault,
  output logic             eff_wr,
  output logic             eff_x,
  output logic             eff_usr,
  output logic             eff_glb
);
  import perm_pkg::*;

  leaf_t   g_leaf, n_leaf;
  acc_e    acc_t;
  logic    gf, nf, gx, nx_ok;
  result_t res, res_q;

  assign g_leaf = '{wr: g_wr, usr: g_usr, nx: g_nx};
  assign n_leaf = '{wr: n_wr, usr: n_usr, nx: n_nx};
  assign acc_t  = acc_e'(acc);

  guest_check #(.CPL_W(CPL_W), .USER_CPL(USER_CPL)) u_gchk (
    .leaf(g_leaf), .nxe(g_nxe), .wp(g_wp), .cpl(cpl), .acc(acc_t),
    .fault(gf), .exec_ok(gx)
  );

  nested_check u_nchk (
    .leaf(n_leaf), .nxe(h_nxe), .acc(acc_t),
    .fault(nf), .exec_ok(nx_ok)
  );

  attr_merge u_merge (
    .g_leaf(g_leaf), .n_leaf(n_leaf), .g_glb(g_glb),
    .g_fault_in(gf), .n_fault_in(nf),
    .g_exec_ok(gx), .n_exec_ok(nx_ok), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) res_q <= res;
    end
  end

  assign g_fault = res_q.g_fault;
  assign n_fault = res_q.n_fault;
  assign eff_wr  = res_q.wr;
  assign eff_x   = res_q.x;
  assign eff_usr = res_q.usr;
  assign eff_glb = res_q.glb;
endmodule

// File: rtl/perm_combiner_chk.sv
module perm_combiner_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic g_wr,
  input logic g_usr,
  input logic g_glb,
  input logic n_wr,
  input logic n_usr,
  input logic out_valid,
  input logic g_fault,
  input logic n_fault,
  input logic eff_wr,
  input logic eff_x,
  input logic eff_usr,
  input logic eff_glb
);
  // R9
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(g_fault && n_fault));

  // R3
  wr_both_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(g_wr && n_wr)) |=> !eff_wr);

  // R7
  glb_guest_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (eff_glb == $past(g_glb)) && (eff_usr == $past(g_usr)));

  // R8
  nusr_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !n_usr) |=> (n_fault || g_fault));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid && $stable(eff_wr) && $stable(eff_x)
                   && $stable(g_fault) && $stable(n_fault));
endmodule

bind perm_combiner perm_combiner_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .g_wr(g_wr), .g_usr(g_usr), .g_glb(g_glb), .n_wr(n_wr), .n_usr(n_usr),
  .out_valid(out_valid), .g_fault(g_fault), .n_fault(n_fault),
  .eff_wr(eff_wr), .eff_x(eff_x), .eff_usr(eff_usr), .eff_glb(eff_glb)
);

// File: tb/perm_combiner_tb_top.sv
module perm_combiner_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, req_valid;
  logic g_wr, g_usr, g_nx, g_glb, n_wr, n_usr, n_nx, g_nxe, h_nxe, g_wp;
  logic [1:0] cpl, acc;
  logic out_valid, g_fault, n_fault, eff_wr, eff_x, eff_usr, eff_glb;

  int n_cmp = 0;
  int n_bad = 0;

  perm_combiner dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .g_wr(g_wr), .g_usr(g_usr), .g_nx(g_nx), .g_glb(g_glb),
    .n_wr(n_wr), .n_usr(n_usr), .n_nx(n_nx),
    .g_nxe(g_nxe), .h_nxe(h_nxe), .g_wp(g_wp), .cpl(cpl), .acc(acc),
    .out_valid(out_valid), .g_fault(g_fault), .n_fault(n_fault),
    .eff_wr(eff_wr), .eff_x(eff_x), .eff_usr(eff_usr), .eff_glb(eff_glb)
  );

  // reference model state
  logic m_v, m_gf, m_nf, m_wr, m_x, m_usr, m_glb;

  always @(posedge clk) begin
    bit wr_a, fx_a, gfa, nfa, gex, nex;
    if (rst) begin
      {m_v, m_gf, m_nf, m_wr, m_x, m_usr, m_glb} <= '0;
    end else begin
      m_v <= req_valid;
      if (req_valid) begin
        wr_a = (acc == 2'b01);
        fx_a = (acc == 2'b10);
        gex  = (g_nxe == 1'b0) || (g_nx == 1'b0);
        nex  = (h_nxe == 1'b0) || (n_nx == 1'b0);
        gfa  = 0;
        if (wr_a && !g_wr) begin
          if (cpl == 2'd3) gfa = 1;
          else if (g_wp) gfa = 1;
        end
        if (cpl == 2'd3 && !g_usr) gfa = 1;
        if (fx_a && !gex) gfa = 1;
        nfa = 0;
        if (!n_usr) nfa = 1;
        if (wr_a && !n_wr) nfa = 1;
        if (fx_a && !nex) nfa = 1;
        if (gfa) nfa = 0;
        m_gf  <= gfa;
        m_nf  <= nfa;
        m_wr  <= g_wr & n_wr;
        m_x   <= gex & nex;
        m_usr <= g_usr;
        m_glb <= g_glb;
      end
    end
  end

  task automatic cmp1(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      cmp1("R2 out_valid", out_valid, m_v);
      cmp1("R4/R6/R8 g_fault", g_fault, m_gf);
      cmp1("R6/R8/R9 n_fault", n_fault, m_nf);
      cmp1("R3 eff_wr", eff_wr, m_wr);
      cmp1("R5 eff_x", eff_x, m_x);
      cmp1("R7 eff_usr", eff_usr, m_usr);
      cmp1("R7 eff_glb", eff_glb, m_glb);
    end
  end

  task automatic drive(bit v, logic [13:0] b);
    {g_wr, g_usr, g_nx, g_glb, n_wr, n_usr, n_nx, g_nxe, h_nxe, g_wp} = b[13:4];
    cpl = b[3:2];
    acc = b[1:0];
    req_valid = v;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1, 14'h3fff);
    repeat (3) @(negedge clk);
    // R1: outputs cleared after reset edges
    cmp1("R1 out_valid", out_valid, 1'b0);
    cmp1("R1 g_fault", g_fault, 1'b0);
    cmp1("R1 eff_wr", eff_wr, 1'b0);
    cmp1("R1 eff_glb", eff_glb, 1'b0);
    rst = 1'b0;
    drive(0, 14'h0);
    @(negedge clk);
    // R4: supervisor write to read-only guest page, wp clear: no fault; nested ok
    // bits: g_wr g_usr g_nx g_glb n_wr n_usr n_nx g_nxe h_nxe g_wp
    drive(1, {10'b0101110000, 2'd0, 2'b01});
    @(negedge clk);
    cmp1("R4 wp clear supervisor", g_fault, 1'b0);
    cmp1("R3 eff_wr read-only guest", eff_wr, 1'b0);
    // R4: same with wp set faults
    drive(1, {10'b0101110001, 2'd0, 2'b01});
    @(negedge clk);
    cmp1("R4 wp set supervisor", g_fault, 1'b1);
    // R8: nested read-only write faults at nested level, wp irrelevant
    drive(1, {10'b1100010001, 2'd3, 2'b01});
    @(negedge clk);
    cmp1("R8 nested read-only write", n_fault, 1'b1);
    // R9: guest and nested both violated
    drive(1, {10'b0000000000, 2'd3, 2'b01});
    @(negedge clk);
    cmp1("R9 guest priority g", g_fault, 1'b1);
    cmp1("R9 guest priority n", n_fault, 1'b0);
    // R2: hold when idle
    drive(0, 14'h0);
    @(negedge clk);
    cmp1("R2 hold g_fault", g_fault, 1'b1);
    // exhaustive sweep with idle gaps
    for (int i = 0; i < 16384; i++) begin
      drive((i % 5) != 4, 14'(i));
      @(negedge clk);
    end
    drive(0, 14'h0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule